// File: doc/BRIEF.md
# Interleaved Burst Cache Read Sequencer

This block drives the data SRAM of a second-level cache that sits behind a processor bus with four-transfer read bursts. Once the tag side reports a hit, the sequencer times each transfer, asserts chip-select, output-enable and write-enable for the bank that holds the word, presents a word address to each bank, and returns one ready pulse to the processor per transfer. The fourth ready of a burst is marked as the last one.

The read timing follows an X-Y-Y-Y pattern. The first transfer takes X clocks (2 or 3). Each of the three following transfers takes Y clocks (1 or 2). When the dual-bank mode is on, even words sit in bank 0 and odd words sit in bank 1. While one bank returns its word, the other bank already holds the address of the next word in the burst, so follow-on transfers can take a single clock. In single-bank mode every word comes from bank 0 and Y is never shorter than 2. Writes and non-burst reads are single transfers and get no address prediction. A write takes Y clocks plus an optional extra wait state.

The configuration inputs are sampled when a request is accepted and must stay stable while that access runs. The state machine has four states:
- `ST_IDLE`: no access is in progress.
- `ST_RD_BURST`: a four-beat read.
- `ST_RD_SINGLE`: a one-beat read.
- `ST_WRITE`: a one-beat write.

The transitions are:
- accept-burst: IDLE to RD_BURST.
- accept-single: IDLE to RD_SINGLE.
- accept-write: IDLE to WRITE.
- finish: any busy state back to IDLE, on the ready that carries `last`.

A request with hit low, and any request made while the block is busy, leaves the block in IDLE or in its current state.

Top module: `cache_burst_seq`

## Requirements
- R1: After reset, `rdy`, `last` and all of `sram_cs`, `sram_oe` and `sram_we` are low.
- R2: A read burst accepted at clock edge E0 raises `rdy` in cycles X, X+Y, X+2Y and X+3Y after E0. X is 3 when `cfg_lead_long` is high and 2 otherwise. Y is 2 when `cfg_follow_long` is high and 1 otherwise, before the single-bank rule of R6 is applied.
- R3: Beat k of a burst transfers word `start ^ k`, where start is `req_addr[3:2]`. This gives the orders 0-1-2-3, 1-0-3-2, 2-3-0-1 and 3-2-1-0. During the ready of beat k, the bank delivering the word shows the word address `{req_addr[AW-1:4], start ^ k}`.
- R4: In dual-bank mode (`cfg_dual` = 1), a word whose bit 0 is 0 uses bank 0 and a word whose bit 0 is 1 uses bank 1. In single-bank mode every access uses bank 0, and `sram_cs[1]` stays low.
- R5: In a dual-bank burst, at the ready of beat k (k < 3), the idle bank already shows the address of word k+1. Both banks are selected for the whole burst.
- R6: With `cfg_dual` = 0, Y is 2 even when `cfg_follow_long` is low.
- R7: A write is one transfer. `rdy` and `last` rise together Y + `cfg_wr_wait` cycles after E0. `sram_we` is high on the target bank for the whole transfer, and `sram_oe` stays low.
- R8: A non-burst read is one transfer of X cycles, with `last` on its ready. Only the target bank is selected. The other bank's address does not change.
- R9: `rdy` is high for exactly one cycle at the end of each transfer. `last` is high only with the final ready of an access.
- R10: `sram_oe` is high only for the bank of the current read beat. It is never high on both banks at once, and it is never high together with `sram_we`.
- R11: A request with `hit` low starts nothing: no strobe and no ready follow, and a later hit request is served normally.
- R12: A request raised while an access is in progress is ignored. The running access completes unchanged, and the block returns to idle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request, sampled in idle |
| req_write | input | 1 | Request is a write |
| req_burst | input | 1 | Read request is a four-beat burst |
| req_addr | input | AW-2 | Word address (byte address bits AW-1:2) |
| hit | input | 1 | Tag hit for the request |
| cfg_lead_long | input | 1 | First transfer takes 3 clocks instead of 2 |
| cfg_follow_long | input | 1 | Follow-on transfers take 2 clocks instead of 1 |
| cfg_wr_wait | input | 1 | One extra write wait state |
| cfg_dual | input | 1 | Interleave words across two banks |
| sram_cs | output | 2 | Per-bank chip-select, active high |
| sram_oe | output | 2 | Per-bank output-enable, active high |
| sram_we | output | 2 | Per-bank write-enable, active high |
| bank0_addr | output | AW-2 | Word address presented to bank 0 |
| bank1_addr | output | AW-2 | Word address presented to bank 1 |
| rdy | output | 1 | Transfer complete, one clock per transfer |
| last | output | 1 | Final transfer of the access |

## Verification
Every result is timed from the edge E0 that samples the request. No output depends combinationally on `req`, so strobes and addresses change only at edges after E0. A transfer's ready is due in cycle X, X+Y, X+2Y or X+3Y after E0 for a read, and in cycle Y plus the write wait for a write. The lookahead address must already be present in the cycle of the preceding ready. The bench raises the request at a falling edge, waits for E0, and then compares every output at each falling edge against a schedule computed from the configuration. This covers the cycle after the final ready, when all strobes must be low again. Address checks are made in the ready cycles, when both the delivering bank and the predicted bank are due.

// File: rtl/cache_seq_pkg.sv
package cache_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_BURST,
        ST_RD_SINGLE,
        ST_WRITE
    } seq_state_e;

    // Word position of beat k for a burst starting at word s (toggle order).
    function automatic logic [1:0] burst_word(input logic [1:0] s, input logic [1:0] k);
        return s ^ k;
    endfunction

endpackage

// File: rtl/cache_beat_timer.sv
module cache_beat_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/cache_bank_addr.sv
module cache_bank_addr #(
    parameter int NB  = 2,
    parameter int WAW = 30
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NB-1:0]           ld,
    input  logic [NB-1:0][WAW-1:0]  ld_val,
    output logic [NB-1:0][WAW-1:0]  q
);
    for (genvar b = 0; b < NB; b++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[b] <= '0;
            end else if (ld[b]) begin
                q[b] <= ld_val[b];
            end
        end
    end

endmodule

// File: rtl/cache_seq_ctrl.sv
module cache_seq_ctrl
    import cache_seq_pkg::*;
#(
    parameter int WAW = 30,
    parameter int CW  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  logic                  req_write,
    input  logic                  req_burst,
    input  logic [WAW-1:0]        req_word,
    input  logic                  hit,
    input  logic                  cfg_lead_long,
    input  logic                  cfg_follow_long,
    input  logic                  cfg_wr_wait,
    input  logic                  cfg_dual,
    input  logic                  timer_expired,
    output logic                  timer_load,
    output logic [CW-1:0]         timer_val,
    output logic [1:0]            addr_ld,
    output logic [1:0][WAW-1:0]   addr_val,
    output logic [1:0]            sram_cs,
    output logic [1:0]            sram_oe,
    output logic [1:0]            sram_we,
    output logic                  rdy,
    output logic                  last
);
    localparam int LW = WAW - 2;

    seq_state_e state_q, state_d;
    logic [LW-1:0] line_q;
    logic [1:0]    start_q;
    logic [1:0]    beat_q;
    logic          dual_q;
    logic [CW-1:0] ylen_q;

    logic          accept;
    logic [CW-1:0] ylen_in;
    logic [CW-1:0] first_len;
    logic [1:0]    cur_word;
    logic          cur_bank;
    logic          start_bank;
    logic          busy;
    logic          rdy_c;
    logic          last_c;

    assign accept     = (state_q == ST_IDLE) && req && hit;
    assign ylen_in    = (cfg_follow_long || !cfg_dual) ? CW'(2) : CW'(1);
    assign first_len  = req_write ? (ylen_in + CW'(cfg_wr_wait))
                                  : (cfg_lead_long ? CW'(3) : CW'(2));
    assign start_bank = cfg_dual & req_word[0];
    assign cur_word   = burst_word(start_q, beat_q);
    assign cur_bank   = dual_q & cur_word[0];
    assign busy       = (state_q != ST_IDLE);
    assign rdy_c      = busy && timer_expired;
    assign last_c     = rdy_c && ((state_q != ST_RD_BURST) || (beat_q == 2'd3));

    // State register and access context.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            line_q  <= '0;
            start_q <= '0;
            beat_q  <= '0;
            dual_q  <= 1'b0;
            ylen_q  <= CW'(2);
        end else begin
            state_q <= state_d;
            if (accept) begin
                line_q  <= req_word[WAW-1:2];
                start_q <= req_word[1:0];
                beat_q  <= '0;
                dual_q  <= cfg_dual;
                ylen_q  <= ylen_in;
            end else if (rdy_c && !last_c) begin
                beat_q  <= beat_q + 2'd1;
            end
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (req_write)      state_d = ST_WRITE;
                    else if (req_burst) state_d = ST_RD_BURST;
                    else                state_d = ST_RD_SINGLE;
                end
            end
            ST_RD_BURST, ST_RD_SINGLE, ST_WRITE: begin
                if (last_c) state_d = ST_IDLE;
            end
        endcase
    end

    // Beat timer and bank address loads.
    always_comb begin
        timer_load = 1'b0;
        timer_val  = '0;
        addr_ld    = '0;
        addr_val   = '0;
        if (accept) begin
            timer_load           = 1'b1;
            timer_val            = first_len - CW'(1);
            addr_ld[start_bank]  = 1'b1;
            addr_val[start_bank] = req_word;
            if (cfg_dual && req_burst && !req_write) begin
                addr_ld[~start_bank]  = 1'b1;
                addr_val[~start_bank] = {req_word[WAW-1:2], burst_word(req_word[1:0], 2'd1)};
            end
        end else if (rdy_c && !last_c) begin
            timer_load = 1'b1;
            timer_val  = ylen_q - CW'(1);
            if (dual_q) begin
                if (beat_q <= 2'd1) begin
                    addr_ld[cur_bank]  = 1'b1;
                    addr_val[cur_bank] = {line_q, burst_word(start_q, beat_q + 2'd2)};
                end
            end else begin
                addr_ld[0]  = 1'b1;
                addr_val[0] = {line_q, burst_word(start_q, beat_q + 2'd1)};
            end
        end
    end

    // Outputs.
    always_comb begin
        sram_oe = '0;
        sram_we = '0;
        sram_cs = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RD_BURST: begin
                sram_oe[cur_bank] = 1'b1;
                sram_cs           = dual_q ? 2'b11 : 2'b01;
            end
            ST_RD_SINGLE: begin
                sram_oe[cur_bank] = 1'b1;
                sram_cs[cur_bank] = 1'b1;
            end
            ST_WRITE: begin
                sram_we[cur_bank] = 1'b1;
                sram_cs[cur_bank] = 1'b1;
            end
        endcase
        rdy  = rdy_c;
        last = last_c;
    end

    // R11
    miss_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req && !hit) |=> (state_q == ST_IDLE));

    // R2
    lead_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_write) |=> !rdy);

    // R4
    single_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !dual_q) |-> !sram_cs[1]);

    // R9
    more_beats_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !last) |=> (state_q == ST_RD_BURST));

    // R12
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last_c) |=> ($stable(start_q) && $stable(line_q)));

endmodule

// File: rtl/cache_burst_seq.sv
module cache_burst_seq #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_write,
    input  logic          req_burst,
    input  logic [AW-1:2] req_addr,
    input  logic          hit,
    input  logic          cfg_lead_long,
    input  logic          cfg_follow_long,
    input  logic          cfg_wr_wait,
    input  logic          cfg_dual,
    output logic [1:0]    sram_cs,
    output logic [1:0]    sram_oe,
    output logic [1:0]    sram_we,
    output logic [AW-3:0] bank0_addr,
    output logic [AW-3:0] bank1_addr,
    output logic          rdy,
    output logic          last
);
    localparam int WAW = AW - 2;
    localparam int CW  = 2;
    localparam int NB  = 2;

    logic                    timer_load;
    logic [CW-1:0]           timer_val;
    logic                    timer_expired;
    logic [NB-1:0]           addr_ld;
    logic [NB-1:0][WAW-1:0]  addr_val;
    logic [NB-1:0][WAW-1:0]  addr_q;

    cache_seq_ctrl #(.WAW(WAW), .CW(CW)) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .req             (req),
        .req_write       (req_write),
        .req_burst       (req_burst),
        .req_word        (req_addr),
        .hit             (hit),
        .cfg_lead_long   (cfg_lead_long),
        .cfg_follow_long (cfg_follow_long),
        .cfg_wr_wait     (cfg_wr_wait),
        .cfg_dual        (cfg_dual),
        .timer_expired   (timer_expired),
        .timer_load      (timer_load),
        .timer_val       (timer_val),
        .addr_ld         (addr_ld),
        .addr_val        (addr_val),
        .sram_cs         (sram_cs),
        .sram_oe         (sram_oe),
        .sram_we         (sram_we),
        .rdy             (rdy),
        .last            (last)
    );

    cache_beat_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .expired  (timer_expired)
    );

    cache_bank_addr #(.NB(NB), .WAW(WAW)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (addr_ld),
        .ld_val (addr_val),
        .q      (addr_q)
    );

    assign bank0_addr = addr_q[0];
    assign bank1_addr = addr_q[1];

    // R10
    oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sram_oe) && !((|sram_oe) && (|sram_we)));

    // R5
    lookahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !last && sram_cs == 2'b11) |->
        (bank0_addr[WAW-1:2] == bank1_addr[WAW-1:2] && !bank0_addr[0] && bank1_addr[0]));

    // R5
    handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !last && sram_cs == 2'b11 && sram_oe == 2'b01) |=> (sram_oe == 2'b10));

    // R9
    last_with_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !last);

endmodule

// File: tb/tb_cache_burst_seq.sv
module tb_cache_burst_seq;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0, req_write = 1'b0, req_burst = 1'b0, hit = 1'b0;
    logic [AW-1:2] req_addr = '0;
    logic          cfg_lead_long = 1'b0, cfg_follow_long = 1'b0, cfg_wr_wait = 1'b0, cfg_dual = 1'b0;
    logic [1:0]    sram_cs, sram_oe, sram_we;
    logic [AW-3:0] bank0_addr, bank1_addr;
    logic          rdy, last;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cache_burst_seq #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write), .req_burst(req_burst),
        .req_addr(req_addr), .hit(hit), .cfg_lead_long(cfg_lead_long),
        .cfg_follow_long(cfg_follow_long), .cfg_wr_wait(cfg_wr_wait), .cfg_dual(cfg_dual),
        .sram_cs(sram_cs), .sram_oe(sram_oe), .sram_we(sram_we),
        .bank0_addr(bank0_addr), .bank1_addr(bank1_addr), .rdy(rdy), .last(last)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-3:0] bank_q(input bit b);
        return b ? bank1_addr : bank0_addr;
    endfunction

    // Drives one access and checks every cycle against the schedule from the requirements.
    task automatic do_access(input string tag, input bit wr, input bit bu, input logic [AW-3:0] a,
                             input bit lead, input bit fol, input bit wws, input bit dual, input bit poke);
        int yeff, first, nb, tend, k;
        logic [1:0] w0, w;
        logic [AW-5:0] line;
        bit b0, b;
        logic [AW-3:0] other_before;
        logic [7:0] act_v, exp_v;
        logic [1:0] e_oe, e_we, e_cs;
        bit e_rdy, e_last;
        yeff  = (fol || !dual) ? 2 : 1;
        first = wr ? yeff + int'(wws) : (lead ? 3 : 2);
        nb    = (bu && !wr) ? 4 : 1;
        tend  = first + (nb - 1) * yeff;
        w0    = a[1:0];
        line  = a[AW-3:2];
        b0    = dual & w0[0];
        other_before = bank_q(!b0);
        @(negedge clk);
        req = 1'b1; req_write = wr; req_burst = bu; req_addr = a; hit = 1'b1;
        cfg_lead_long = lead; cfg_follow_long = fol; cfg_wr_wait = wws; cfg_dual = dual;
        @(posedge clk);
        for (int i = 1; i <= tend + 1; i++) begin
            @(negedge clk);
            if (poke) begin
                if (i == 1) begin req_write = 1'b1; req_addr = ~a; end
                if (i == 3) req = 1'b0;
            end else if (i == 1) begin
                req = 1'b0;
            end
            k = 0;
            while (k < nb - 1 && i > first + k * yeff) k++;
            w = w0 ^ 2'(k);
            b = dual & w[0];
            e_oe = '0; e_we = '0; e_cs = '0; e_rdy = 1'b0; e_last = 1'b0;
            if (i <= tend) begin
                e_rdy  = (i == first + k * yeff);
                e_last = e_rdy && (k == nb - 1);
                if (wr) e_we[b] = 1'b1; else e_oe[b] = 1'b1;
                if (bu && !wr && dual) e_cs = 2'b11; else e_cs[b] = 1'b1;
            end
            act_v = {rdy, last, sram_oe, sram_we, sram_cs};
            exp_v = {e_rdy, e_last, e_oe, e_we, e_cs};
            chk(act_v == exp_v, $sformatf("%s strobes cycle %0d", tag, i), 64'(act_v), 64'(exp_v));
            if (e_rdy) begin
                // R3 delivering bank address
                chk(bank_q(b) == {line, w}, $sformatf("R3 beat %0d address", k),
                    64'(bank_q(b)), 64'({line, w}));
                // R5 predicted address on idle bank
                if (bu && !wr && dual && k < 3)
                    chk(bank_q(!b) == {line, w0 ^ 2'(k + 1)}, $sformatf("R5 lookahead beat %0d", k),
                        64'(bank_q(!b)), 64'({line, w0 ^ 2'(k + 1)}));
                // R8 no prediction for single transfers
                if (!bu && !wr && dual)
                    chk(bank_q(!b0) == other_before, "R8 other bank untouched",
                        64'(bank_q(!b0)), 64'(other_before));
            end
        end
        req = 1'b0; req_write = 1'b0; req_burst = 1'b0; hit = 1'b0;
    endtask

    task automatic t_reset;
        act_idle_check("R1 reset state");
    endtask

    task automatic act_idle_check(input string tag);
        logic [7:0] v;
        v = {rdy, last, sram_oe, sram_we, sram_cs};
        chk(v == 8'h00, tag, 64'(v), 64'h0);
    endtask

    task automatic t_bursts_dual;
        do_access("R2", 0, 1, 30'h0123_4560 >> 0, 0, 0, 0, 1, 0);
        do_access("R3", 0, 1, 30'h0000_0A01, 1, 0, 0, 1, 0);
        do_access("R9", 0, 1, 30'h0000_0B02, 0, 1, 0, 1, 0);
        do_access("R10", 0, 1, 30'h0000_0C03, 1, 1, 0, 1, 0);
    endtask

    task automatic t_bursts_single;
        do_access("R6", 0, 1, 30'h0000_0D01, 0, 0, 0, 0, 0);
        do_access("R4", 0, 1, 30'h0000_0E02, 1, 1, 0, 0, 0);
        do_access("R4", 0, 1, 30'h0000_0E03, 0, 1, 0, 0, 0);
    endtask

    task automatic t_writes;
        do_access("R7", 1, 0, 30'h0000_1001, 0, 0, 0, 1, 0);
        do_access("R7", 1, 0, 30'h0000_1002, 0, 0, 1, 1, 0);
        do_access("R7", 1, 0, 30'h0000_1003, 1, 1, 1, 0, 0);
    endtask

    task automatic t_single_reads;
        do_access("R4", 0, 1, 30'h0000_2000, 0, 0, 0, 1, 0);
        do_access("R8", 0, 0, 30'h0000_3001, 0, 0, 0, 1, 0);
        do_access("R8", 0, 0, 30'h0000_3102, 1, 0, 0, 1, 0);
    endtask

    task automatic t_miss;
        @(negedge clk);
        req = 1'b1; req_write = 1'b0; req_burst = 1'b1; req_addr = 30'h0000_4000; hit = 1'b0;
        cfg_dual = 1'b1;
        @(negedge clk);
        req = 1'b0;
        for (int i = 0; i < 5; i++) begin
            act_idle_check("R11 miss ignored");
            @(negedge clk);
        end
        do_access("R11", 0, 1, 30'h0000_4001, 0, 0, 0, 1, 0);
    endtask

    task automatic t_busy_req;
        do_access("R12", 0, 1, 30'h0000_5002, 0, 0, 0, 1, 1);
        @(negedge clk);
        act_idle_check("R12 idle after burst");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_bursts_dual;
        t_bursts_single;
        t_writes;
        t_single_reads;
        t_miss;
        t_busy_req;
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule